// File: doc/BRIEF.md
# Two-Level Interrupt Event Router

The block collects 64 system event inputs and folds them onto 10 host interrupt lines in two routing stages. Each event names one of 10 channels, and each channel names one of 10 hosts. Any number of events may share a channel, and any number of channels may share a host. Every event has its own pending latch and its own enable. Every host has its own enable. One global enable gates all host outputs.

Software programs the block through a simple 32-bit register bus that has no wait states. Writes take effect at the clock edge. Reads are combinational from the current state. For each host, a readout register gives the winning pending event by a fixed priority, so a handler can service the lines one event at a time.

The map tables pack one 4-bit entry into the low nibble of each byte, four entries to a 32-bit word. Enables and status clears are write-one-to-act. Host enables are set and cleared by writing an index.

Top module: `evt_router`

## Requirements
- R1: After reset all map entries are 0, so every event routes to channel 0 and every channel routes to host 0. All event enables, host enables, the global enable and all pending bits are 0. Every host output is low, and every host readout returns 0x80000000.
- R2: The channel map for event e sits in word e/4 at byte address 0x100 + 4*(e/4), in bits [8*(e mod 4)+3 : 8*(e mod 4)]. Upper nibbles of each byte are not stored and read as 0.
- R3: The host map for channel c sits in word c/4 at byte address 0x200 + 4*(c/4), using the same nibble layout as R2. Upper nibbles are not stored and read as 0.
- R4: A write of 1 to bit b of 0x004 or 0x008 sets the enable of event b or event 32+b. A write of 1 to the same bit of 0x00C or 0x010 clears that enable. Zero bits have no effect. Reads of 0x004/0x00C return the enables of events 0–31, and reads of 0x008/0x010 return those of events 32–63.
- R5: An event input that is high at a rising clock edge sets that event's pending bit, whatever its enable. The bit stays set until a 1 is written to its bit in 0x014 (events 0–31) or 0x018 (events 32–63). While the input is still high, the bit sets again. Reads of 0x014/0x018 return the pending bits.
- R6: Writing index i to 0x01C enables host i, and writing i to 0x020 disables it. An index of 10 or more changes nothing. Reads of either address return the host enable mask, with bit i for host i.
- R7: Bit 0 of 0x000 is the global enable. While it is 0, every host output is low.
- R8: Host output h is high exactly when the global enable is set, host h is enabled, and at least one event is both pending and enabled and routes through its channel to host h.
- R9: The readout for host h at 0x300 + 4*h returns the number of the winning routed, pending, enabled event in bits [9:0], with all other bits 0. The event on the lowest-numbered channel wins. Within a channel, the lowest event number wins. Host enable and global enable do not affect the readout.
- R10: When no routed, pending, enabled event exists for host h, its readout is 0x80000000. A channel value of 10–15 routes an event nowhere, and a host value of 10–15 routes a channel nowhere.
- R11: Unmapped addresses read as 0 and ignore writes. This covers control words above 0x020, map words beyond the last entry, readouts for hosts 10 and up, and any address at 0x400 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 64 | System event inputs, sampled each clock edge |
| bus_addr_i | input | 12 | Register byte address (bits 1:0 ignored) |
| bus_we_i | input | 1 | Write strobe for one cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| host_irq_o | output | 10 | Host interrupt outputs |

## Verification
On every cycle, the assertions check these properties:
- A pending bit never drops without a status-clear write.
- A high event input always leaves its pending bit set.
- A host output falls after its host is disabled or the global enable is cleared.
- A "none" readout never coincides with a raised host output.
- Reads of unmapped space return zero.

The two-stage routing, the channel-then-event priority order, the nibble packing of both map tables and the independence of pending from enable can only be shown by the bench. Its scenarios program specific maps, raise chosen events and compare the readouts and outputs with values computed from the requirements.

// File: rtl/evt_router_pkg.sv
package evt_router_pkg;
  localparam int unsigned BUS_AW = 12;
  localparam int unsigned MAP_W  = 4;

  localparam logic [3:0] RGN_CTL  = 4'h0;
  localparam logic [3:0] RGN_CMAP = 4'h1;
  localparam logic [3:0] RGN_HMAP = 4'h2;
  localparam logic [3:0] RGN_PIDX = 4'h3;

  localparam logic [5:0] W_GLB     = 6'd0;
  localparam logic [5:0] W_EN_SET0 = 6'd1;
  localparam logic [5:0] W_EN_SET1 = 6'd2;
  localparam logic [5:0] W_EN_CLR0 = 6'd3;
  localparam logic [5:0] W_EN_CLR1 = 6'd4;
  localparam logic [5:0] W_ST_CLR0 = 6'd5;
  localparam logic [5:0] W_ST_CLR1 = 6'd6;
  localparam logic [5:0] W_HEN_SET = 6'd7;
  localparam logic [5:0] W_HEN_CLR = 6'd8;

  localparam logic [31:0] PIDX_NONE = 32'h8000_0000;
endpackage

// File: rtl/evt_pend_bank.sv
module evt_pend_bank #(
  parameter int unsigned N_EVT = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_EVT-1:0] en_set_i,
  input  logic [N_EVT-1:0] en_clr_i,
  input  logic [N_EVT-1:0] st_clr_i,
  output logic [N_EVT-1:0] en_o,
  output logic [N_EVT-1:0] pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      pend_o <= '0;
    end else begin
      en_o   <= (en_o | en_set_i) & ~en_clr_i;
      // a still-high input wins over a clear in the same cycle
      pend_o <= (pend_o & ~st_clr_i) | evt_i;
    end
  end
endmodule

// File: rtl/evt_chan_sel.sv
module evt_chan_sel
  import evt_router_pkg::*;
#(
  parameter int unsigned N_EVT = 64,
  parameter int unsigned EW    = 6,
  parameter int unsigned CH    = 0
) (
  input  logic [N_EVT-1:0]            active_i,
  input  logic [N_EVT-1:0][MAP_W-1:0] cmap_i,
  output logic                        hit_o,
  output logic [EW-1:0]               idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int e = N_EVT - 1; e >= 0; e--) begin
      if (active_i[e] && (cmap_i[e] == MAP_W'(CH))) begin
        hit_o = 1'b1;
        idx_o = EW'(e);
      end
    end
  end
endmodule

// File: rtl/evt_host_arb.sv
module evt_host_arb
  import evt_router_pkg::*;
#(
  parameter int unsigned N_CH = 10,
  parameter int unsigned EW   = 6,
  parameter int unsigned HOST = 0
) (
  input  logic [N_CH-1:0]            ch_hit_i,
  input  logic [N_CH-1:0][EW-1:0]    ch_idx_i,
  input  logic [N_CH-1:0][MAP_W-1:0] hmap_i,
  output logic                       hit_o,
  output logic [EW-1:0]              idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int c = N_CH - 1; c >= 0; c--) begin
      if (ch_hit_i[c] && (hmap_i[c] == MAP_W'(HOST))) begin
        hit_o = 1'b1;
        idx_o = ch_idx_i[c];
      end
    end
  end
endmodule

// File: rtl/evt_router.sv
module evt_router
  import evt_router_pkg::*;
#(
  parameter int unsigned N_EVT  = 64,
  parameter int unsigned N_CH   = 10,
  parameter int unsigned N_HOST = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [N_HOST-1:0] host_irq_o
);
  localparam int unsigned EW  = $clog2(N_EVT);
  localparam int unsigned HIW = $clog2(N_HOST);

  logic [3:0] rgn;
  logic [5:0] wsel;
  assign rgn  = bus_addr_i[11:8];
  assign wsel = bus_addr_i[7:2];

  logic ctl_we;
  assign ctl_we = bus_we_i && (rgn == RGN_CTL);

  // state
  logic                        glb_q;
  logic [N_HOST-1:0]           hen_q;
  logic [N_EVT-1:0][MAP_W-1:0] cmap_q;
  logic [N_CH-1:0][MAP_W-1:0]  hmap_q;
  logic [N_EVT-1:0]            en_q, pend_q;

  // write-one strobes, widened to 64 then cut to N_EVT
  logic [63:0] en_set64, en_clr64, st_clr64;
  always_comb begin
    en_set64 = '0;
    en_clr64 = '0;
    st_clr64 = '0;
    if (ctl_we) begin
      case (wsel)
        W_EN_SET0: en_set64[31:0]  = bus_wdata_i;
        W_EN_SET1: en_set64[63:32] = bus_wdata_i;
        W_EN_CLR0: en_clr64[31:0]  = bus_wdata_i;
        W_EN_CLR1: en_clr64[63:32] = bus_wdata_i;
        W_ST_CLR0: st_clr64[31:0]  = bus_wdata_i;
        W_ST_CLR1: st_clr64[63:32] = bus_wdata_i;
        default: ;
      endcase
    end
  end

  evt_pend_bank #(.N_EVT(N_EVT)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .en_set_i (en_set64[N_EVT-1:0]),
    .en_clr_i (en_clr64[N_EVT-1:0]),
    .st_clr_i (st_clr64[N_EVT-1:0]),
    .en_o     (en_q),
    .pend_o   (pend_q)
  );

  logic hidx_ok;
  assign hidx_ok = (bus_wdata_i < 32'(N_HOST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_q <= 1'b0;
      hen_q <= '0;
    end else if (ctl_we) begin
      if (wsel == W_GLB) glb_q <= bus_wdata_i[0];
      if (wsel == W_HEN_SET && hidx_ok) hen_q[bus_wdata_i[HIW-1:0]] <= 1'b1;
      if (wsel == W_HEN_CLR && hidx_ok) hen_q[bus_wdata_i[HIW-1:0]] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmap_q <= '0;
    end else if (bus_we_i && rgn == RGN_CMAP) begin
      for (int e = 0; e < N_EVT; e++)
        if (wsel == 6'(e / 4)) cmap_q[e] <= bus_wdata_i[(e % 4) * 8 +: MAP_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hmap_q <= '0;
    end else if (bus_we_i && rgn == RGN_HMAP) begin
      for (int c = 0; c < N_CH; c++)
        if (wsel == 6'(c / 4)) hmap_q[c] <= bus_wdata_i[(c % 4) * 8 +: MAP_W];
    end
  end

  // stage 1: per channel, lowest active event
  logic [N_EVT-1:0]         active;
  logic [N_CH-1:0]          ch_hit;
  logic [N_CH-1:0][EW-1:0]  ch_idx;
  assign active = en_q & pend_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    evt_chan_sel #(.N_EVT(N_EVT), .EW(EW), .CH(c)) u_sel (
      .active_i (active),
      .cmap_i   (cmap_q),
      .hit_o    (ch_hit[c]),
      .idx_o    (ch_idx[c])
    );
  end

  // stage 2: per host, lowest hitting channel
  logic [N_HOST-1:0]         host_hit;
  logic [N_HOST-1:0][EW-1:0] host_idx;

  for (genvar h = 0; h < N_HOST; h++) begin : g_host
    evt_host_arb #(.N_CH(N_CH), .EW(EW), .HOST(h)) u_arb (
      .ch_hit_i (ch_hit),
      .ch_idx_i (ch_idx),
      .hmap_i   (hmap_q),
      .hit_o    (host_hit[h]),
      .idx_o    (host_idx[h])
    );
  end

  assign host_irq_o = {N_HOST{glb_q}} & hen_q & host_hit;

  // read mux
  logic [63:0] en64, pend64;
  assign en64   = 64'(en_q);
  assign pend64 = 64'(pend_q);

  always_comb begin
    bus_rdata_o = '0;
    case (rgn)
      RGN_CTL: begin
        case (wsel)
          W_GLB:                bus_rdata_o = {31'b0, glb_q};
          W_EN_SET0, W_EN_CLR0: bus_rdata_o = en64[31:0];
          W_EN_SET1, W_EN_CLR1: bus_rdata_o = en64[63:32];
          W_ST_CLR0:            bus_rdata_o = pend64[31:0];
          W_ST_CLR1:            bus_rdata_o = pend64[63:32];
          W_HEN_SET, W_HEN_CLR: bus_rdata_o = 32'(hen_q);
          default:              bus_rdata_o = '0;
        endcase
      end
      RGN_CMAP: begin
        for (int e = 0; e < N_EVT; e++)
          if (wsel == 6'(e / 4)) bus_rdata_o[(e % 4) * 8 +: MAP_W] = cmap_q[e];
      end
      RGN_HMAP: begin
        for (int c = 0; c < N_CH; c++)
          if (wsel == 6'(c / 4)) bus_rdata_o[(c % 4) * 8 +: MAP_W] = hmap_q[c];
      end
      RGN_PIDX: begin
        for (int h = 0; h < N_HOST; h++)
          if (wsel == 6'(h)) bus_rdata_o = host_hit[h] ? 32'(host_idx[h]) : PIDX_NONE;
      end
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_router_chk.sv
module evt_router_chk
  import evt_router_pkg::*;
#(
  parameter int unsigned N_EVT  = 64,
  parameter int unsigned N_HOST = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_EVT-1:0]  evt_i,
  input logic [BUS_AW-1:0] bus_addr_i,
  input logic              bus_we_i,
  input logic [31:0]       bus_wdata_i,
  input logic [31:0]       bus_rdata_o,
  input logic [N_HOST-1:0] host_irq_o,
  input logic [N_EVT-1:0]  pend_i
);
  logic [3:0] rgn;
  logic [5:0] wsel;
  logic       st_clr_wr, glb_off_wr, hclr_wr;
  assign rgn        = bus_addr_i[11:8];
  assign wsel       = bus_addr_i[7:2];
  assign st_clr_wr  = bus_we_i && rgn == RGN_CTL && (wsel == W_ST_CLR0 || wsel == W_ST_CLR1);
  assign glb_off_wr = bus_we_i && rgn == RGN_CTL && wsel == W_GLB && !bus_wdata_i[0];
  assign hclr_wr    = bus_we_i && rgn == RGN_CTL && wsel == W_HEN_CLR &&
                      bus_wdata_i < 32'(N_HOST);

  // R5
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_clr_wr |=> ((pend_i & $past(pend_i)) == $past(pend_i)));

  // R5
  pend_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_i & $past(evt_i)) == $past(evt_i)));

  // R7
  glb_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glb_off_wr |=> (host_irq_o == '0));

  // R6
  host_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hclr_wr |=> !host_irq_o[$past(bus_wdata_i[3:0])]);

  // R10
  none_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rgn == RGN_PIDX && wsel < 6'(N_HOST) && bus_rdata_o[31]) |-> !host_irq_o[wsel[3:0]]);

  // R11
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rgn > RGN_PIDX) |-> (bus_rdata_o == '0));
endmodule

bind evt_router evt_router_chk #(.N_EVT(N_EVT), .N_HOST(N_HOST)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_i       (evt_i),
  .bus_addr_i  (bus_addr_i),
  .bus_we_i    (bus_we_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .host_irq_o  (host_irq_o),
  .pend_i      (pend_q)
);

// File: tb/tb_evt_router.sv
module tb_evt_router;
  localparam time PERIOD = 4ns;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] evt_i = '0;
  logic [11:0] bus_addr_i = '0;
  logic        bus_we_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [9:0]  host_irq_o;

  always #(PERIOD / 2) clk = ~clk;

  evt_router dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .evt_i       (evt_i),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .host_irq_o  (host_irq_o)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   pushed = 0, popped = 0;
  int   n_chk = 0, n_err = 0;
  bit   done = 0;

  // monitor: pops expectations and compares with the live outputs
  initial begin
    forever begin
      exp_t it;
      logic [31:0] act;
      wait (pushed != popped);
      it  = q.pop_front();
      act = it.is_irq ? 32'(host_irq_o) : bus_rdata_o;
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
      popped++;
    end
  end

  task automatic push_exp(bit is_irq, logic [31:0] e, string tag);
    exp_t it;
    it.is_irq = is_irq;
    it.exp    = e;
    it.tag    = tag;
    q.push_back(it);
    pushed++;
    wait (popped == pushed);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr_i  = a;
    bus_wdata_i = d;
    bus_we_i    = 1'b1;
    @(negedge clk);
    bus_we_i    = 1'b0;
  endtask

  task automatic rd_exp(logic [11:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    bus_addr_i = a;
    #1;
    push_exp(1'b0, e, tag);
  endtask

  task automatic irq_exp(logic [31:0] e, string tag);
    @(negedge clk);
    #1;
    push_exp(1'b1, e, tag);
  endtask

  task automatic pulse(int e);
    @(negedge clk);
    evt_i[e] = 1'b1;
    @(negedge clk);
    evt_i[e] = 1'b0;
  endtask

  initial begin
    #(PERIOD * 50000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd_exp(12'h000, 32'h0, "R1 global enable");
    rd_exp(12'h100, 32'h0, "R1 channel map");
    rd_exp(12'h01C, 32'h0, "R1 host enables");
    rd_exp(12'h300, 32'h8000_0000, "R1 host0 readout");
    irq_exp(32'h0, "R1 outputs");

    // R2 event 5 -> channel 3, upper nibble dropped
    wr(12'h104, 32'h0000_F300);
    rd_exp(12'h104, 32'h0000_0300, "R2 nibble pack");
    // R3 channel 3 -> host 7
    wr(12'h200, 32'hA700_0000);
    rd_exp(12'h200, 32'h0700_0000, "R3 nibble pack");

    // R4 enable set, zero write has no effect
    wr(12'h004, 32'h0000_0020);
    wr(12'h004, 32'h0);
    rd_exp(12'h004, 32'h0000_0020, "R4 set mask");
    rd_exp(12'h00C, 32'h0000_0020, "R4 clear alias");

    // R5 pulse latches; R7 global off keeps output low
    pulse(5);
    rd_exp(12'h014, 32'h0000_0020, "R5 latched");
    rd_exp(12'h31C, 32'd5, "R9 host7 readout");
    irq_exp(32'h0, "R7 global off");

    // R6 host enable by index
    wr(12'h01C, 32'd7);
    rd_exp(12'h01C, 32'h0000_0080, "R6 host set");
    wr(12'h01C, 32'd12);
    rd_exp(12'h01C, 32'h0000_0080, "R6 bad index");
    irq_exp(32'h0, "R7 still gated");
    wr(12'h000, 32'h1);
    irq_exp(32'h0000_0080, "R8 host7 up");

    // R9 channel priority: events 40,41 on channel 1 -> host 7
    wr(12'h128, 32'h0000_0101);
    wr(12'h200, 32'h0700_0700);
    wr(12'h008, 32'h0000_0300);
    pulse(41);
    rd_exp(12'h31C, 32'd41, "R9 lower channel wins");
    pulse(40);
    rd_exp(12'h31C, 32'd40, "R9 lower event wins");

    // R5 status clear, R8 disable keeps pending
    wr(12'h018, 32'h0000_0100);
    rd_exp(12'h31C, 32'd41, "R5 clear 40");
    wr(12'h010, 32'h0000_0200);
    rd_exp(12'h31C, 32'd5, "R8 disabled skipped");
    rd_exp(12'h018, 32'h0000_0200, "R5 pending kept");
    rd_exp(12'h008, 32'h0000_0100, "R4 clear mask");

    // R6 host clear; readout unaffected
    wr(12'h020, 32'd7);
    irq_exp(32'h0, "R6 host cleared");
    rd_exp(12'h020, 32'h0, "R6 mask read");
    rd_exp(12'h31C, 32'd5, "R9 readout ignores host enable");

    // R10 none
    wr(12'h014, 32'h0000_0020);
    rd_exp(12'h31C, 32'h8000_0000, "R10 none");

    // R5 level input re-latches over clear
    @(negedge clk);
    evt_i[5] = 1'b1;
    wr(12'h014, 32'h0000_0020);
    rd_exp(12'h014, 32'h0000_0020, "R5 level relatch");
    @(negedge clk);
    evt_i[5] = 1'b0;
    wr(12'h014, 32'h0000_0020);
    rd_exp(12'h014, 32'h0, "R5 cleared");

    // R8 default routing event 0 -> ch0 -> host0
    wr(12'h004, 32'h1);
    wr(12'h01C, 32'd0);
    pulse(0);
    irq_exp(32'h0000_0001, "R8 default route");
    rd_exp(12'h300, 32'd0, "R9 host0 readout");

    // R10 channel 12 routes nowhere
    wr(12'h100, 32'h0000_000C);
    rd_exp(12'h300, 32'h8000_0000, "R10 channel out of range");
    irq_exp(32'h0, "R10 output low");

    // R11 unmapped
    wr(12'h040, 32'hFFFF_FFFF);
    rd_exp(12'h040, 32'h0, "R11 ctl hole");
    rd_exp(12'h000, 32'h1, "R11 state intact");
    wr(12'h400, 32'hFFFF_FFFF);
    rd_exp(12'h400, 32'h0, "R11 high region");
    rd_exp(12'h328, 32'h0, "R11 host10 readout");

    // R7 global off
    wr(12'h004, 32'h0000_0020);
    wr(12'h01C, 32'd7);
    pulse(5);
    irq_exp(32'h0000_0080, "R8 host7 again");
    wr(12'h000, 32'h0);
    irq_exp(32'h0, "R7 global cleared");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule